// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a single serial data line into a word of parallel outputs, so a controller with few pins can drive many binary loads. Bits are clocked into an internal shift chain, one stage per enabled clock edge. The parallel outputs do not come from that chain. They come from a separate holding register that is updated only when a load strobe is given. Because of this, a new word can be shifted in while the outputs keep showing the previous word, and all outputs change together on the load edge.

The last shift stage drives a cascade output. That output can feed the serial input of a second expander, so several devices can be chained on one data line. An active-high clear empties the shift chain without disturbing the outputs. An output enable forces all parallel outputs low when it is deasserted. A parameter selects which end of the chain the serial data enters. That choice sets how stage numbers map to output bit positions.

Top module: `sipo_latched_expander`

## Requirements
- R1: While the active-low `rst_n` is low, every shift stage and every holding bit is zero. Therefore `par_out` and `cascade_out` read zero as well.
- R2: On a rising edge with `shift_en` high and `clr` low, `ser_in` enters stage 1 and each stage k takes the old value of stage k-1. A bit reaches stage N after N such edges. With the default entry side, stage k maps to `par_out[k-1]`. With `shift_en` low, the stages hold their values.
- R3: `cascade_out` always equals the last stage (stage WIDTH). A bit presented at `ser_in` therefore appears on `cascade_out` after WIDTH shifting edges.
- R4: While `load_stb` is low, the holding register does not change, whatever happens on `ser_in`, `shift_en` or `clr`.
- R5: On a rising edge with `load_stb` high, the whole shift chain is copied into the holding register in that single cycle. Stage k goes to holding bit k-1.
- R6: When `shift_en` and `load_stb` are both high on the same edge, the holding register captures the chain contents from before that shift.
- R7: On a rising edge with `clr` high, every stage becomes zero, and `clr` takes priority over `shift_en`. The holding register is not affected by `clr`. If `load_stb` is also high on that edge, the holding register captures the contents from before the clear.
- R8: When `oe` is low, `par_out` is all zeros without waiting for a clock edge, and the holding register keeps its contents. When `oe` is high, `par_out` equals the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every stage and the holding register |
| rst_n | input | 1 | Asynchronous active-low reset of the chain and the holding register |
| ser_in | input | 1 | Serial data input |
| shift_en | input | 1 | Advances the shift chain by one stage on the clock edge |
| load_stb | input | 1 | Copies the shift chain into the holding register |
| clr | input | 1 | Synchronous clear of the shift chain only |
| oe | input | 1 | Output enable; low forces the parallel outputs to zero |
| par_out | output | WIDTH | Parallel outputs taken from the holding register |
| cascade_out | output | 1 | Last shift stage, used to chain the next device |

## Verification
The hardest cases to set up are the same-edge collisions: load together with shift, and load together with clear. A collision is only visible when the chain holds a value that differs both from the holding register and from the word the shift or clear would produce. The stimulus first shifts in an irregular pattern and loads it. It then shifts in a different pattern, and only after that fires the strobe in the same cycle as a further shift or a clear. Finally it loads again, so that the chain state left behind by each collision is also brought out to the ports.

// File: rtl/sipo_pkg.sv
`timescale 1ns/1ps
package sipo_pkg;
   // Side of the chain where serial data enters
   typedef enum logic {
      ENTER_LOW  = 1'b0,  // data enters stage 1 = bit 0, moves toward the top bit
      ENTER_HIGH = 1'b1   // data enters stage 1 = top bit, moves toward bit 0
   } entry_e;

   // Map a one-based stage number to its bit index in a WIDTH-wide vector
   function automatic int stage_to_bit(input int width, input entry_e side, input int stage);
      return (side == ENTER_LOW) ? (stage - 1) : (width - stage);
   endfunction
endpackage

// File: rtl/sipo_shift_chain.sv
`timescale 1ns/1ps
module sipo_shift_chain
   import sipo_pkg::*;
#(
   parameter int     WIDTH = 8,
   parameter entry_e ENTRY = ENTER_LOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             clr,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q,
   output logic             tail_q
);
   localparam int LAST_BIT = stage_to_bit(WIDTH, ENTRY, WIDTH);

   logic [WIDTH-1:0] shifted;

   initial begin
      assert (WIDTH >= 2) else $error("sipo_shift_chain: WIDTH must be at least 2");
   end

   generate
      if (ENTRY == ENTER_LOW) begin : g_enter_low
         always_comb shifted = {stage_q[WIDTH-2:0], ser_in};
      end else begin : g_enter_high
         always_comb shifted = {ser_in, stage_q[WIDTH-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= '0;
      else if (clr)      stage_q <= '0;
      else if (shift_en) stage_q <= shifted;
   end

   assign tail_q = stage_q[LAST_BIT];
endmodule

// File: rtl/sipo_hold_reg.sv
`timescale 1ns/1ps
module sipo_hold_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (WIDTH >= 1) else $error("sipo_hold_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/sipo_out_gate.sv
`timescale 1ns/1ps
module sipo_out_gate #(
   parameter int WIDTH = 8
) (
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] y
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign y[i] = d[i] & en;
      end
   endgenerate
endmodule

// File: rtl/sipo_latched_expander.sv
`timescale 1ns/1ps
module sipo_latched_expander
   import sipo_pkg::*;
#(
   parameter int     WIDTH = 8,
   parameter entry_e ENTRY = ENTER_LOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             shift_en,
   input  logic             load_stb,
   input  logic             clr,
   input  logic             oe,
   output logic [WIDTH-1:0] par_out,
   output logic             cascade_out
);
   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] hold_q;

   initial begin
      assert (WIDTH >= 2 && WIDTH <= 1024)
         else $error("sipo_latched_expander: WIDTH out of range");
   end

   sipo_shift_chain #(.WIDTH(WIDTH), .ENTRY(ENTRY)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .clr      (clr),
      .ser_in   (ser_in),
      .stage_q  (stage_q),
      .tail_q   (cascade_out)
   );

   sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_stb),
      .d     (stage_q),
      .q     (hold_q)
   );

   sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
      .en (oe),
      .d  (hold_q),
      .y  (par_out)
   );
endmodule

// File: rtl/sipo_expander_chk.sv
`timescale 1ns/1ps
module sipo_expander_chk
   import sipo_pkg::*;
#(
   parameter int     WIDTH = 8,
   parameter entry_e ENTRY = ENTER_LOW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shift_en,
   input logic             load_stb,
   input logic             clr,
   input logic             oe,
   input logic [WIDTH-1:0] stage_q,
   input logic [WIDTH-1:0] hold_q,
   input logic [WIDTH-1:0] par_out,
   input logic             cascade_out
);
   localparam int LAST_BIT = stage_to_bit(WIDTH, ENTRY, WIDTH);

   // R2
   idle_chain_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clr) |=> $stable(stage_q));

   // R3
   cascade_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_out == stage_q[LAST_BIT]);

   // R4
   hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> $stable(hold_q));

   // R5
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> hold_q == $past(stage_q));

   // R7
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> stage_q == '0);

   // R8
   oe_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> par_out == '0);

   // R8
   oe_high_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> par_out == hold_q);
endmodule

bind sipo_latched_expander sipo_expander_chk #(.WIDTH(WIDTH), .ENTRY(ENTRY)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .shift_en    (shift_en),
   .load_stb    (load_stb),
   .clr         (clr),
   .oe          (oe),
   .stage_q     (stage_q),
   .hold_q      (hold_q),
   .par_out     (par_out),
   .cascade_out (cascade_out)
);

// File: tb/sipo_latched_expander_test.sv
`timescale 1ns/1ps
module sipo_latched_expander_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_in = 1'b0;
   logic         shift_en = 1'b0;
   logic         load_stb = 1'b0;
   logic         clr = 1'b0;
   logic         oe = 1'b1;
   logic [W-1:0] par_out;
   logic         cascade_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   // behavioural model: queue element 0 is stage 1
   bit           chain_m[$];
   logic [W-1:0] hold_m;

   always #2.5 clk = ~clk;

   sipo_latched_expander #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
      .load_stb(load_stb), .clr(clr), .oe(oe),
      .par_out(par_out), .cascade_out(cascade_out)
   );

   task automatic compare(input string tag);
      logic [W-1:0] exp_par;
      logic         exp_cas;
      exp_par = oe ? hold_m : '0;
      exp_cas = chain_m[W-1];
      vectors++;
      if (par_out !== exp_par || cascade_out !== exp_cas) begin
         miscompares++;
         $display("FAIL %s: par_out=%h cascade_out=%b expected par_out=%h cascade_out=%b",
                  tag, par_out, cascade_out, exp_par, exp_cas);
      end
   endtask

   task automatic step(input bit si, input bit sh, input bit ld, input bit cl,
                       input bit en, input string tag);
      bit snap[$];
      ser_in = si; shift_en = sh; load_stb = ld; clr = cl; oe = en;
      @(posedge clk);
      snap = chain_m;
      if (ld) for (int k = 0; k < W; k++) hold_m[k] = snap[k];
      if (cl) begin
         for (int k = 0; k < W; k++) chain_m[k] = 1'b0;
      end else if (sh) begin
         chain_m.push_front(si);
         void'(chain_m.pop_back());
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic shift_word(input logic [W-1:0] word, input string tag);
      // sends bit W-1 first, so after W shifts stage k holds word[k-1]
      for (int i = W - 1; i >= 0; i--) step(word[i], 1, 0, 0, 1, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < W; k++) chain_m.push_back(1'b0);
      hold_m = '0;
      // R1: reset state, with shifting and loading requested during reset
      ser_in = 1; shift_en = 1; load_stb = 1;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      step(0, 0, 0, 0, 1, "R1 after release");

      // R2 / R3: a single one walks through the chain to the cascade output
      step(1, 1, 0, 0, 1, "R2 walk");
      for (int i = 1; i < W; i++) step(0, 1, 0, 0, 1, "R3 walk to tail");
      step(0, 0, 1, 0, 1, "R5 load walking one");
      // R2: shifting disabled keeps the stages
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, "R2 idle hold");
      step(0, 0, 1, 0, 1, "R2 idle then load");

      // R4: outputs stay while a new word is shifted in
      shift_word(8'b1011_0010, "R4 shifting under stable outputs");
      step(0, 0, 1, 0, 1, "R5 load 0xB2");
      shift_word(8'b0110_1101, "R4 second word");

      // R6: load on the same edge as a shift captures the pre-shift chain
      step(1, 1, 1, 0, 1, "R6 shift with load");
      step(0, 0, 1, 0, 1, "R6 chain after collision");

      // R7: clear empties chain only; clear with load captures pre-clear
      shift_word(8'b1100_0101, "R7 prepare");
      step(1, 1, 0, 1, 1, "R7 clear beats shift");
      step(0, 0, 1, 0, 1, "R7 load after clear");
      shift_word(8'b0011_1010, "R7 prepare again");
      step(0, 0, 1, 1, 1, "R7 clear with load");
      step(0, 0, 1, 0, 1, "R7 chain empty after clear");
      shift_word(8'b1111_0000, "R7 refill");
      step(0, 0, 1, 0, 1, "R5 load 0xF0");

      // R8: output enable gating, hold survives
      step(0, 0, 0, 0, 0, "R8 oe low");
      step(1, 1, 0, 0, 0, "R8 oe low while shifting");
      step(0, 0, 0, 0, 1, "R8 oe back high");
      oe = 0; #0.5;
      compare("R8 oe low combinational");
      oe = 1; #0.5;
      compare("R8 oe high combinational");

      // mixed pattern with loads at irregular points
      for (int i = 0; i < 40; i++)
         step(((i * 7) % 5) < 2, (i % 4) != 3, (i % 6) == 5, (i % 13) == 12, (i % 9) != 8,
              "R2 R5 mixed");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule